// File: doc/BRIEF.md
# Temperature Limit Alert Unit

This block watches the stream of finished temperature conversions and decides whether an over-temperature alert is active. Each result is compared against a programmable upper limit and a programmable lower limit, using only the upper eleven bits of the 16-bit two's complement result. A reading above the upper limit raises the alert. A reading below the lower limit drops it, so the pin has hysteresis between the two limits. Software can also drop the alert early, either by writing the alert-reset bit of the configuration byte or by sending a clear pulse from an alert-response bus cycle. If the temperature is still too high, the next conversion raises the alert again.

The block holds the two limit registers and the configuration byte. It drives the alert pin with a selectable polarity and an enable, and it keeps two history flags: a high flag and a low flag. Each flag records that its limit was crossed and stays set until the status register is read after the condition has ended. The bus slave and the converter sequencer are outside the block. They supply write strobes, the conversion-done strobe with its result, the status-read strobe and the alert-response clear pulse.

Top module: `temp_alert_top`

## Requirements
- R1: After reset the upper limit reads 7FE0h, the lower limit reads 8000h and the configuration reads 40h. The alert is inactive, so with the default active-low polarity the pin and `alertStat` are 1. Both flags are 0.
- R2: Comparisons happen only in a cycle with `convDone` high. They are signed and use result bits 15:5 against limit bits 15:5, so result bits 4:0 have no effect. A reading equal to a limit neither sets nor clears the alert.
- R3: A reading strictly above the upper limit makes the alert active from the cycle after the `convDone` strobe.
- R4: A reading strictly below the lower limit makes the alert inactive in the cycle after the strobe. A reading between the limits leaves the alert unchanged.
- R5: Two events clear the alert in the next cycle: a configuration write with bit 3 = 1, and a pulse on `araClr`. A conversion above the upper limit in the same cycle as a clear wins, and the alert is active afterwards. A later over-limit conversion re-raises the alert.
- R6: Configuration bit 5 = 1 disables the alert. The pin then sits at its inactive level and the internal alert state clears, so re-enabling shows an inactive pin until the next over-limit conversion.
- R7: Configuration bit 4 selects the polarity. With bit 4 = 1 the pin is 1 while the alert is active; with bit 4 = 0 the pin is 0 while the alert is active. The inactive level is the opposite value.
- R8: `alertStat` always equals the logic level of `alertPin`.
- R9: `highFlag` sets on any reading above the upper limit. It clears only on a `csRd` strobe when the latest reading is not above the upper limit. A reading that coincides with the strobe counts as the latest reading.
- R10: `lowFlag` sets on any reading below the lower limit. It clears only on a `csRd` strobe when the latest reading is not below the lower limit.
- R11: Both limit registers read 0 in bits 4:0 whatever is written there. Configuration bits 3 and 2 always read 0, and the other configuration bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | One-cycle strobe: a conversion result is valid |
| convData | input | 16 | Conversion result, two's complement, left justified |
| limWrData | input | 16 | Write data for either limit register |
| hiLimWr | input | 1 | Write strobe for the upper limit |
| loLimWr | input | 1 | Write strobe for the lower limit |
| cfgWr | input | 1 | Write strobe for the configuration byte |
| cfgWrData | input | 8 | Configuration write data (bit 5 disable, bit 4 polarity, bit 3 alert reset) |
| araClr | input | 1 | Clear pulse from an alert-response bus cycle |
| csRd | input | 1 | Strobe: control/status register is being read |
| alertPin | output | 1 | Alert output level |
| alertStat | output | 1 | Status bit mirroring the alert pin level |
| highFlag | output | 1 | Sticky upper-limit history flag |
| lowFlag | output | 1 | Sticky lower-limit history flag |
| hiLimRd | output | 16 | Upper limit read value |
| loLimRd | output | 16 | Lower limit read value |
| cfgRd | output | 8 | Configuration read value |

## Verification
Two pairs of functions can land in the same cycle.

- A clear (alert-response pulse or alert-reset write) can coincide with a conversion. The bench drives `araClr` high in the same cycle as an over-limit `convDone` and expects the alert active afterwards, because the conversion takes priority.
- A status read can coincide with the flag logic. The bench issues status reads while the latest reading is still over the limit and checks that the flag holds. After an in-range reading, a read must clear the flag.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;
  // Strobes the datapath hands to the control
  typedef struct packed {
    logic valid;   // a conversion finished this cycle
    logic over;    // reading above upper limit
    logic under;   // reading below lower limit
    logic rstReq;  // alert-reset bit written as 1
  } tempEvt_t;

  // Static configuration fields the control needs
  typedef struct packed {
    logic alertOff;
    logic activeHigh;
  } cfgCtl_t;
endpackage

// File: rtl/temp_alert_dp.sv
module temp_alert_dp
  import temp_alert_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMP_W = 11,
  parameter int CFG_W = 8,
  parameter logic [DATA_W-1:0] HI_RESET = 16'h7FE0,
  parameter logic [DATA_W-1:0] LO_RESET = 16'h8000,
  parameter logic [CFG_W-1:0] CFG_RESET = 8'h40,
  parameter int OFF_BIT = 5,
  parameter int POL_BIT = 4,
  parameter int RST_BIT = 3,
  parameter int SHOT_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic [DATA_W-1:0] limWrData,
  input  logic              hiLimWr,
  input  logic              loLimWr,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgWrData,
  output tempEvt_t          evt,
  output cfgCtl_t           cfgCtl,
  output logic [DATA_W-1:0] hiLimRd,
  output logic [DATA_W-1:0] loLimRd,
  output logic [CFG_W-1:0]  cfgRd
);
  localparam int LSB = DATA_W - CMP_W;

  logic [CMP_W-1:0] hiLim;
  logic [CMP_W-1:0] loLim;
  logic [CFG_W-1:0] cfgReg;
  logic [CFG_W-1:0] cfgMask;
  logic signed [CMP_W-1:0] reading;

  // Bits that always read zero in the configuration byte
  always_comb begin
    cfgMask = '1;
    cfgMask[RST_BIT] = 1'b0;
    cfgMask[SHOT_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiLim  <= HI_RESET[DATA_W-1:LSB];
      loLim  <= LO_RESET[DATA_W-1:LSB];
      cfgReg <= CFG_RESET & cfgMask;
    end else begin
      if (hiLimWr) hiLim <= limWrData[DATA_W-1:LSB];
      if (loLimWr) loLim <= limWrData[DATA_W-1:LSB];
      if (cfgWr) cfgReg <= cfgWrData & cfgMask;
    end
  end

  assign reading = $signed(convData[DATA_W-1:LSB]);

  always_comb begin
    evt.valid  = convDone;
    evt.over   = convDone && (reading > $signed(hiLim));
    evt.under  = convDone && (reading < $signed(loLim));
    evt.rstReq = cfgWr && cfgWrData[RST_BIT];
  end

  assign cfgCtl.alertOff   = cfgReg[OFF_BIT];
  assign cfgCtl.activeHigh = cfgReg[POL_BIT];

  assign hiLimRd = {hiLim, {LSB{1'b0}}};
  assign loLimRd = {loLim, {LSB{1'b0}}};
  assign cfgRd   = cfgReg;

  // R11: a limit write is seen on the read port in the next cycle
  p_limit_store_r11: assert property (@(posedge clk) disable iff (!rstN)
    hiLimWr |=> hiLimRd[DATA_W-1:LSB] == $past(limWrData[DATA_W-1:LSB]));
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import temp_alert_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  tempEvt_t evt,
  input  cfgCtl_t  cfgCtl,
  input  logic     araClr,
  input  logic     csRd,
  output logic     alertPin,
  output logic     alertStat,
  output logic     highFlag,
  output logic     lowFlag
);
  logic alertActive;
  logic overLast;
  logic underLast;
  logic overNow;
  logic underNow;
  logic clrReq;

  assign clrReq   = evt.rstReq || araClr;
  assign overNow  = evt.valid ? evt.over  : overLast;
  assign underNow = evt.valid ? evt.under : underLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alertActive <= 1'b0;
      overLast    <= 1'b0;
      underLast   <= 1'b0;
      highFlag    <= 1'b0;
      lowFlag     <= 1'b0;
    end else begin
      if (evt.valid) begin
        overLast  <= evt.over;
        underLast <= evt.under;
      end
      // Alert state: disable wins, then an over reading, then clears
      if (cfgCtl.alertOff)              alertActive <= 1'b0;
      else if (evt.valid && evt.over)   alertActive <= 1'b1;
      else if (evt.valid && evt.under)  alertActive <= 1'b0;
      else if (clrReq)                  alertActive <= 1'b0;
      // History flags
      if (evt.valid && evt.over)        highFlag <= 1'b1;
      else if (csRd && !overNow)        highFlag <= 1'b0;
      if (evt.valid && evt.under)       lowFlag <= 1'b1;
      else if (csRd && !underNow)       lowFlag <= 1'b0;
    end
  end

  always_comb begin
    if (alertActive && !cfgCtl.alertOff) alertPin = cfgCtl.activeHigh;
    else                                 alertPin = !cfgCtl.activeHigh;
  end
  assign alertStat = alertPin;

  // R3: an over-limit reading on an enabled alert raises it
  p_over_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evt.valid && evt.over && !cfgCtl.alertOff) |=> alertActive);
  // R4: an under-limit reading lowers it
  p_under_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evt.valid && evt.under && !evt.over) |=> !alertActive);
  // R5: a clear without a competing over reading lowers it
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !(evt.valid && evt.over)) |=> !alertActive);
  // R6: a disabled alert holds no state
  p_disabled_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgCtl.alertOff |=> !alertActive);
  // R9: without a status read the high flag cannot drop
  p_high_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (highFlag && !csRd) |=> highFlag);
  // R10: without a status read the low flag cannot drop
  p_low_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lowFlag && !csRd) |=> lowFlag);
endmodule

// File: rtl/temp_alert_top.sv
module temp_alert_top
  import temp_alert_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMP_W = 11,
  parameter int CFG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic [DATA_W-1:0] limWrData,
  input  logic              hiLimWr,
  input  logic              loLimWr,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              araClr,
  input  logic              csRd,
  output logic              alertPin,
  output logic              alertStat,
  output logic              highFlag,
  output logic              lowFlag,
  output logic [DATA_W-1:0] hiLimRd,
  output logic [DATA_W-1:0] loLimRd,
  output logic [CFG_W-1:0]  cfgRd
);
  tempEvt_t evt;
  cfgCtl_t  cfgCtl;

  temp_alert_dp #(.DATA_W(DATA_W), .CMP_W(CMP_W), .CFG_W(CFG_W)) u_dp (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .limWrData(limWrData), .hiLimWr(hiLimWr), .loLimWr(loLimWr),
    .cfgWr(cfgWr), .cfgWrData(cfgWrData), .evt(evt), .cfgCtl(cfgCtl),
    .hiLimRd(hiLimRd), .loLimRd(loLimRd), .cfgRd(cfgRd)
  );

  temp_alert_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .cfgCtl(cfgCtl), .araClr(araClr),
    .csRd(csRd), .alertPin(alertPin), .alertStat(alertStat),
    .highFlag(highFlag), .lowFlag(lowFlag)
  );
endmodule

// File: tb/temp_alert_top_tb.sv
module temp_alert_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convDone = 1'b0;
  logic [15:0] convData = '0;
  logic [15:0] limWrData = '0;
  logic hiLimWr = 1'b0, loLimWr = 1'b0, cfgWr = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic araClr = 1'b0, csRd = 1'b0;
  logic alertPin, alertStat, highFlag, lowFlag;
  logic [15:0] hiLimRd, loLimRd;
  logic [7:0] cfgRd;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  temp_alert_top u_dut (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .limWrData(limWrData), .hiLimWr(hiLimWr), .loLimWr(loLimWr),
    .cfgWr(cfgWr), .cfgWrData(cfgWrData), .araClr(araClr), .csRd(csRd),
    .alertPin(alertPin), .alertStat(alertStat), .highFlag(highFlag),
    .lowFlag(lowFlag), .hiLimRd(hiLimRd), .loLimRd(loLimRd), .cfgRd(cfgRd)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each driver holds its strobe for one cycle; outputs are settled on return
  task automatic conv(input logic [15:0] v);
    @(negedge clk); convDone = 1'b1; convData = v;
    @(negedge clk); convDone = 1'b0;
  endtask
  task automatic wrHi(input logic [15:0] v);
    @(negedge clk); hiLimWr = 1'b1; limWrData = v;
    @(negedge clk); hiLimWr = 1'b0;
  endtask
  task automatic wrLo(input logic [15:0] v);
    @(negedge clk); loLimWr = 1'b1; limWrData = v;
    @(negedge clk); loLimWr = 1'b0;
  endtask
  task automatic wrCfg(input logic [7:0] v);
    @(negedge clk); cfgWr = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWr = 1'b0;
  endtask
  task automatic readCs();
    @(negedge clk); csRd = 1'b1;
    @(negedge clk); csRd = 1'b0;
  endtask
  task automatic ara();
    @(negedge clk); araClr = 1'b1;
    @(negedge clk); araClr = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 hi limit", hiLimRd, 16'h7FE0);
    chk("R1 lo limit", loLimRd, 16'h8000);
    chk("R1 cfg", {8'h0, cfgRd}, 16'h0040);
    chk("R1 pin", {15'h0, alertPin}, 16'h1);
    chk("R1 stat", {15'h0, alertStat}, 16'h1);
    chk("R1 flags", {14'h0, highFlag, lowFlag}, 16'h0);
  endtask

  task automatic testRegs();
    wrHi(16'h191F);
    chk("R11 hi low bits zero", hiLimRd, 16'h1900);
    wrLo(16'h0A1F);
    chk("R11 lo low bits zero", loLimRd, 16'h0A00);
    wrCfg(8'h4C);
    chk("R11 cfg bits 3:2 read zero", {8'h0, cfgRd}, 16'h0040);
    chk("R5 alert-reset on idle leaves pin inactive", {15'h0, alertPin}, 16'h1);
  endtask

  task automatic testThresholds();
    conv(16'h191F);
    chk("R2 equal to hi (low bits ignored) no set", {15'h0, alertPin}, 16'h1);
    conv(16'h1920);
    chk("R3 over sets (active-low pin)", {15'h0, alertPin}, 16'h0);
    chk("R8 stat mirrors pin", {15'h0, alertStat}, 16'h0);
    chk("R9 high flag set", {15'h0, highFlag}, 16'h1);
    readCs();
    chk("R9 read while over keeps flag", {15'h0, highFlag}, 16'h1);
    conv(16'h1000);
    chk("R4 between limits holds alert", {15'h0, alertPin}, 16'h0);
    chk("R9 flag survives in-range reading", {15'h0, highFlag}, 16'h1);
    readCs();
    chk("R9 read after condition gone clears", {15'h0, highFlag}, 16'h0);
    conv(16'h0A00);
    chk("R2 equal to lo no clear", {15'h0, alertPin}, 16'h0);
    conv(16'h09E0);
    chk("R4 under clears", {15'h0, alertPin}, 16'h1);
    chk("R10 low flag set", {15'h0, lowFlag}, 16'h1);
    readCs();
    chk("R10 read while under keeps flag", {15'h0, lowFlag}, 16'h1);
    conv(16'h1000);
    readCs();
    chk("R10 read after condition gone clears", {15'h0, lowFlag}, 16'h0);
  endtask

  task automatic testClears();
    conv(16'h1920);
    wrCfg(8'h48);
    chk("R5 alert-reset write clears", {15'h0, alertPin}, 16'h1);
    conv(16'h1920);
    chk("R5 next over reading re-raises", {15'h0, alertPin}, 16'h0);
    ara();
    chk("R5 ara pulse clears", {15'h0, alertPin}, 16'h1);
    @(negedge clk); araClr = 1'b1; convDone = 1'b1; convData = 16'h1920;
    @(negedge clk); araClr = 1'b0; convDone = 1'b0;
    chk("R5 over reading beats same-cycle clear", {15'h0, alertPin}, 16'h0);
  endtask

  task automatic testEnablePol();
    wrCfg(8'h60);
    chk("R6 disabled pin inactive", {15'h0, alertPin}, 16'h1);
    conv(16'h1920);
    chk("R6 disabled ignores over", {15'h0, alertPin}, 16'h1);
    wrCfg(8'h40);
    chk("R6 re-enable shows cleared state", {15'h0, alertPin}, 16'h1);
    wrCfg(8'h50);
    chk("R7 active-high idle level", {15'h0, alertPin}, 16'h0);
    chk("R8 stat mirrors idle level", {15'h0, alertStat}, 16'h0);
    conv(16'h1920);
    chk("R7 active-high asserted", {15'h0, alertPin}, 16'h1);
    chk("R8 stat mirrors high pin", {15'h0, alertStat}, 16'h1);
    wrCfg(8'h40);
    chk("R7 polarity flip while active", {15'h0, alertPin}, 16'h0);
  endtask

  task automatic testSigned();
    wrLo(16'hF380);
    conv(16'hF400);
    chk("R2 negative reading above lo holds", {15'h0, alertPin}, 16'h0);
    conv(16'hEC00);
    chk("R2 signed under clears", {15'h0, alertPin}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testThresholds();
    testClears();
    testEnablePol();
    testSigned();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule